// File: doc/BRIEF.md
# Paged Write Sequencer with Ready/Busy Status

This block sits behind the serial front end of a small word-organised non-volatile store. The front end decodes each write command and hands it over as strobes. A command strobe carries the kind of write and its start address. A word strobe carries each 16-bit data word. Separate pulses mark every rising serial clock edge and every decoded start bit. The sequencer stages up to one page of four words. It asks an outside protection predicate whether each target address is protected. It starts a self-timed programming cycle only when chip select is released inside the single permitted window. During and after that cycle it reports status on the serial output. The storage itself is a register array of 256 words of 16 bits, and it has a combinational read port.

All inputs are sampled on the system clock. The serial clock appears only as a one-cycle pulse, `sclk_rise_i`. A write becomes visible in the array when the programming cycle ends, which is `CYCLE_CLKS` system clocks after it starts. No command, word, start bit or chip-select event is accepted while a cycle is running. Reset is asynchronous and active low. It is expected to arrive already released in step with `clk`.

Top module: `pagewr_seq`

## Requirements
- R1: After reset every array word reads 0xFFFF, `busy_o` is 0 and `so_oe_o` is 0.
- R2: `cmd_kind_i` uses 0 for a single word, 1 for a page and 2 for write-all. A command commits only if the chip select falls (`cs_i` high in the previous cycle, low now) after the last expected word strobe. There must be no `sclk_rise_i` pulse from that strobe up to and including the cycle of the fall. An early fall, a late fall, or a fall in the same cycle as a rise pulse discards the command and leaves the array unchanged.
- R3: The k-th word of a page write (k counted from 0) lands at the address whose upper six bits are those of the start address and whose two low bits are (start[1:0] + k) mod 4. Words beyond the fourth wrap and overwrite earlier words of the same page.
- R4: `prot_query_o` presents each word's target address when its word strobe arrives, and `prot_hit_i` is sampled with it. If any word of a single or page write is reported protected, the whole command is rejected.
- R5: A write-all stores its one data word into all 256 locations. It is honoured only if `prot_clear_i` is high when the chip select falls.
- R6: A commit also requires `wen_latch_i` high at the chip-select fall. `wp_n_i` must stay high in every cycle from the command strobe through the fall.
- R7: After a commit, `busy_o` stays high for exactly `CYCLE_CLKS` cycles, and the staged words appear in the array when it drops. All strobes and chip-select events arriving during those cycles have no effect.
- R8: From a commit onward, while `cs_i` is high, `so_oe_o` is 1 and `so_o` is 0 during busy and 1 after the cycle ends. The high level holds until a `start_bit_i` pulse or `cs_i` low, after which `so_oe_o` is 0. Whenever `cs_i` is low, `so_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select level |
| sclk_rise_i | input | 1 | Pulse: a rising serial clock edge was seen |
| start_bit_i | input | 1 | Pulse: a new start bit was decoded |
| cmd_valid_i | input | 1 | Pulse: a write command was decoded |
| cmd_kind_i | input | 2 | Write kind: 0 word, 1 page, 2 write-all |
| cmd_addr_i | input | 8 | Start address of the command |
| word_valid_i | input | 1 | Pulse: a full data word was received |
| word_data_i | input | 16 | Data word qualified by `word_valid_i` |
| wen_latch_i | input | 1 | Global write-enable latch state |
| wp_n_i | input | 1 | Write-protect pin, high allows writes |
| prot_query_o | output | 8 | Address offered to the protection predicate |
| prot_hit_i | input | 1 | Predicate result: queried address is protected |
| prot_clear_i | input | 1 | Protection register is in its cleared state |
| rd_addr_i | input | 8 | Array read address |
| rd_data_o | output | 16 | Array read data |
| so_o | output | 1 | Serial output status level |
| so_oe_o | output | 1 | Serial output drive enable |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The closing of the commit window and a further serial clock edge can land in one system clock. The chip-select fall and a `sclk_rise_i` pulse then arrive together, and the sequencer has to treat that as a late release. The bench provokes this by driving both in the same cycle after a single-word frame. It judges the result against its reference model: `busy_o` must stay low, the status enable must stay off, and the addressed word must still read 0xFFFF. It likewise drives a complete frame while a cycle is already running, so that the chip-select fall that would otherwise commit coincides with busy. It then checks that only the first write reaches the array.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    WC_WORD = 2'd0,
    WC_PAGE = 2'd1,
    WC_ALL  = 2'd2
  } wcmd_e;

  typedef enum logic [1:0] {
    FS_IDLE    = 2'd0,
    FS_COLLECT = 2'd1,
    FS_ARMED   = 2'd2
  } fstate_e;
endpackage

// File: rtl/pws_stage.sv
module pws_stage
  import pws_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             busy_i,
  input  logic                             cs_i,
  input  logic                             sclk_rise_i,
  input  logic                             cmd_valid_i,
  input  wcmd_e                            cmd_kind_i,
  input  logic [ADDR_W-1:0]                cmd_addr_i,
  input  logic                             word_valid_i,
  input  logic [DATA_W-1:0]                word_data_i,
  input  logic                             wen_latch_i,
  input  logic                             wp_n_i,
  input  logic                             prot_hit_i,
  input  logic                             prot_clear_i,
  output logic [ADDR_W-1:0]                prot_query_o,
  output logic                             go_o,
  output wcmd_e                            kind_o,
  output logic [ADDR_W-1:0]                base_o,
  output logic [PAGE_WORDS-1:0]            mask_o,
  output logic [PAGE_WORDS-1:0][DATA_W-1:0] data_o
);
  localparam int PW = $clog2(PAGE_WORDS);

  fstate_e                          st_q, st_d;
  wcmd_e                            kind_q, kind_d;
  logic [ADDR_W-1:0]                base_q, base_d;
  logic [PW-1:0]                    ptr_q, ptr_d;
  logic [PAGE_WORDS-1:0]            mask_q, mask_d;
  logic [PAGE_WORDS-1:0][DATA_W-1:0] dat_q, dat_d;
  logic                             hit_q, hit_d;
  logic                             wpbad_q, wpbad_d;
  logic                             cs_q;
  logic                             cs_fall;
  logic                             accept;
  logic                             allow;

  assign accept  = ~busy_i;
  assign cs_fall = cs_q & ~cs_i;
  assign allow   = wen_latch_i & wp_n_i & ~wpbad_q &
                   ((kind_q == WC_ALL) ? prot_clear_i : ~hit_q);
  assign go_o    = accept & cs_fall & (st_q == FS_ARMED) & ~sclk_rise_i &
                   ~cmd_valid_i & allow;

  assign prot_query_o = {base_q[ADDR_W-1:PW], ptr_q};
  assign kind_o       = kind_q;
  assign base_o       = base_q;
  assign mask_o       = mask_q;
  assign data_o       = dat_q;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    base_d  = base_q;
    ptr_d   = ptr_q;
    mask_d  = mask_q;
    dat_d   = dat_q;
    hit_d   = hit_q;
    wpbad_d = wpbad_q;
    if (accept) begin
      if (cmd_valid_i) begin
        st_d    = FS_COLLECT;
        kind_d  = cmd_kind_i;
        base_d  = cmd_addr_i;
        ptr_d   = (cmd_kind_i == WC_ALL) ? '0 : cmd_addr_i[PW-1:0];
        mask_d  = '0;
        hit_d   = 1'b0;
        wpbad_d = ~wp_n_i;
      end else if (cs_fall) begin
        st_d = FS_IDLE;
      end else begin
        if ((st_q != FS_IDLE) && !wp_n_i) wpbad_d = 1'b1;
        unique case (st_q)
          FS_COLLECT: begin
            if (word_valid_i) begin
              dat_d[ptr_q]  = word_data_i;
              mask_d[ptr_q] = 1'b1;
              hit_d         = hit_q | prot_hit_i;
              ptr_d         = ptr_q + 1'b1;
              st_d          = FS_ARMED;
            end
          end
          FS_ARMED: begin
            if (sclk_rise_i) st_d = (kind_q == WC_PAGE) ? FS_COLLECT : FS_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      kind_q  <= WC_WORD;
      base_q  <= '0;
      ptr_q   <= '0;
      mask_q  <= '0;
      dat_q   <= '0;
      hit_q   <= 1'b0;
      wpbad_q <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      base_q  <= base_d;
      ptr_q   <= ptr_d;
      mask_q  <= mask_d;
      dat_q   <= dat_d;
      hit_q   <= hit_d;
      wpbad_q <= wpbad_d;
      cs_q    <= cs_i;
    end
  end

  // R7: a commit always hands over to a running cycle
  a_r7_go_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> busy_i);
  // R7: no commit while a cycle runs
  a_r7_no_go_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !go_o);
  // R2: a commit is never accompanied by a serial clock edge
  a_r2_no_edge_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> !sclk_rise_i && !cs_i);
  // R6: a commit needs the enable latch and the protect pin
  a_r6_enables_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> wen_latch_i && wp_n_i);
endmodule

// File: rtl/pws_timer.sv
module pws_timer #(
  parameter int CYCLE_CLKS = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLE_CLKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign busy_o = busy_q;
  assign done_o = busy_q & (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (go_i) begin
      busy_d = 1'b1;
      cnt_d  = CW'(CYCLE_CLKS - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  // R7: busy cannot drop before the count is exhausted
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (cnt_q != '0) |=> busy_q);
  // R7: completion is a single pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/pws_array.sv
module pws_array
  import pws_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              done_i,
  input  wcmd_e                             kind_i,
  input  logic [ADDR_W-1:0]                 base_i,
  input  logic [PAGE_WORDS-1:0]             mask_i,
  input  logic [PAGE_WORDS-1:0][DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [DATA_W-1:0]                 rd_data_o
);
  localparam int PW    = $clog2(PAGE_WORDS);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(g);
    logic [DATA_W-1:0] q, d;
    logic              sel;

    always_comb begin
      if (kind_i == WC_ALL) sel = 1'b1;
      else sel = (WA[ADDR_W-1:PW] == base_i[ADDR_W-1:PW]) & mask_i[WA[PW-1:0]];
      d = q;
      if (done_i && sel) d = (kind_i == WC_ALL) ? data_i[0] : data_i[WA[PW-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else        q <= d;
    end

    assign words[g] = q;
  end

  assign rd_data_o = words[rd_addr_i];
endmodule

// File: rtl/pagewr_seq.sv
module pagewr_seq
  import pws_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4,
  parameter int CYCLE_CLKS = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sclk_rise_i,
  input  logic              start_bit_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_kind_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_data_i,
  input  logic              wen_latch_i,
  input  logic              wp_n_i,
  output logic [ADDR_W-1:0] prot_query_o,
  input  logic              prot_hit_i,
  input  logic              prot_clear_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              busy_o
);
  logic                              go;
  logic                              done;
  logic                              busy;
  wcmd_e                             kind;
  logic [ADDR_W-1:0]                 base;
  logic [PAGE_WORDS-1:0]             mask;
  logic [PAGE_WORDS-1:0][DATA_W-1:0] data;
  logic                              status_q, status_d;

  pws_stage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)
  ) u_stage (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy),
    .cs_i         (cs_i),
    .sclk_rise_i  (sclk_rise_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_kind_i   (wcmd_e'(cmd_kind_i)),
    .cmd_addr_i   (cmd_addr_i),
    .word_valid_i (word_valid_i),
    .word_data_i  (word_data_i),
    .wen_latch_i  (wen_latch_i),
    .wp_n_i       (wp_n_i),
    .prot_hit_i   (prot_hit_i),
    .prot_clear_i (prot_clear_i),
    .prot_query_o (prot_query_o),
    .go_o         (go),
    .kind_o       (kind),
    .base_o       (base),
    .mask_o       (mask),
    .data_o       (data)
  );

  pws_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go),
    .busy_o (busy),
    .done_o (done)
  );

  pws_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (done),
    .kind_i    (kind),
    .base_i    (base),
    .mask_i    (mask),
    .data_i    (data),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  always_comb begin
    status_d = status_q;
    if (go)                              status_d = 1'b1;
    else if (!busy && (start_bit_i || !cs_i)) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign busy_o  = busy;
  assign so_oe_o = status_q & cs_i;
  assign so_o    = status_q & ~busy;

  // R8: deselected output is never driven
  a_r8_hiz_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> !so_oe_o);
  // R8: driven output shows low while programming
  a_r8_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe_o && busy_o |-> !so_o);
  // R8: ready level persists while selected and no start bit arrives
  a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe_o && !busy_o && !start_bit_i && !go |=> !cs_i || (so_oe_o && so_o));
endmodule

// File: tb/pagewr_seq_tb.sv
`timescale 1ns/1ps
module pagewr_seq_tb;
  localparam int CYC = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic cs, rise, stb, cv, wv, wen, w, pclr;
  logic [1:0]  kind;
  logic [7:0]  addr, rda, pq;
  logic [15:0] wd, rdd;
  logic so, oe, busy, phit;
  int bound;
  int compared = 0, mism = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  always #5 clk = ~clk;

  assign phit = (int'(pq) >= bound);

  pagewr_seq #(.CYCLE_CLKS(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_rise_i(rise), .start_bit_i(stb),
    .cmd_valid_i(cv), .cmd_kind_i(kind), .cmd_addr_i(addr), .word_valid_i(wv),
    .word_data_i(wd), .wen_latch_i(wen), .wp_n_i(w), .prot_query_o(pq),
    .prot_hit_i(phit), .prot_clear_i(pclr), .rd_addr_i(rda), .rd_data_o(rdd),
    .so_o(so), .so_oe_o(oe), .busy_o(busy)
  );

  // behavioural reference model
  int mem [256];
  bit m_busy, m_status, m_csq, m_hit, m_wpbad;
  int m_cnt, m_st, m_kind, m_base, m_ptr;
  bit [3:0] m_mask;
  int m_dat [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 'hFFFF;
      m_busy = 0; m_status = 0; m_csq = 0; m_hit = 0; m_wpbad = 0;
      m_cnt = 0; m_st = 0; m_kind = 0; m_base = 0; m_ptr = 0; m_mask = 0;
      foreach (m_dat[i]) m_dat[i] = 0;
    end else begin
      automatic bit fall = m_csq && !cs;
      automatic bit go = 0;
      automatic bit b0 = m_busy;
      automatic int q = (m_base & 'hFC) | m_ptr;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_kind == 2) foreach (mem[i]) mem[i] = m_dat[0];
          else for (int i = 0; i < 4; i++)
            if (m_mask[i]) mem[(m_base & 'hFC) | i] = m_dat[i];
        end else m_cnt--;
      end else begin
        automatic bit allow = wen && w && !m_wpbad &&
                              ((m_kind == 2) ? pclr : !m_hit);
        if (cv) begin
          m_st = 1; m_kind = kind; m_base = addr;
          m_ptr = (kind == 2) ? 0 : (addr & 3);
          m_mask = 0; m_hit = 0; m_wpbad = !w;
        end else if (fall) begin
          go = (m_st == 2) && !rise && allow;
          m_st = 0;
        end else begin
          if (m_st != 0 && !w) m_wpbad = 1;
          if (m_st == 1 && wv) begin
            m_dat[m_ptr] = wd; m_mask[m_ptr] = 1;
            m_hit = m_hit | (q >= bound);
            m_ptr = (m_ptr + 1) & 3; m_st = 2;
          end else if (m_st == 2 && rise) begin
            m_st = (m_kind == 1) ? 1 : 0;
          end
        end
        if (go) begin m_busy = 1; m_cnt = CYC - 1; end
      end
      if (go) m_status = 1;
      else if (!b0 && (stb || !cs)) m_status = 0;
      m_csq = cs;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mism++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(busy == m_busy, "busy", busy, m_busy);
      chk(oe == (m_status && cs), "so_oe", oe, m_status && cs);
      if (oe) chk(so == !m_busy, "so", so, !m_busy);
      chk(int'(rdd) == mem[rda], "rd_data", rdd, mem[rda]);
    end
  end

  task automatic tick;
    @(posedge clk); #2;
    rise = 0; stb = 0; cv = 0; wv = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin rda = rda + 8'd1; tick(); end
  endtask

  task automatic check_word(input int a, input int exp);
    rda = a[7:0];
    @(negedge clk);
    chk(int'(rdd) == exp, $sformatf("word %0h", a), rdd, exp);
    tick();
  endtask

  task automatic send_cmd(input int k, input int a);
    cs = 1; tick();
    cv = 1; kind = k[1:0]; addr = a[7:0]; tick();
  endtask

  task automatic send_word(input int d);
    rise = 1; tick();
    rise = 1; wv = 1; wd = d[15:0]; tick();
  endtask

  // mode 0 in window, 1 late, 2 same cycle as a rise
  task automatic end_frame(input int mode);
    if (mode == 1) begin rise = 1; tick(); end
    if (mode == 2) rise = 1;
    cs = 0; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      mism++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cs = 0; rise = 0; stb = 0; cv = 0; wv = 0; wen = 1; w = 1; pclr = 0;
    kind = 0; addr = 0; wd = 0; rda = 0; bound = 256;
    repeat (3) @(posedge clk); #2; rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(busy == 0, "reset busy", busy, 0);
    chk(oe == 0, "reset so_oe", oe, 0);
    tick();
    check_word('h00, 'hFFFF); check_word('hFF, 'hFFFF);

    cur_req = "R8";  // single write with status polling
    send_cmd(0, 'h12); send_word('hA5A5); end_frame(0);
    cs = 1; @(negedge clk);
    chk(oe == 1 && so == 0, "busy poll", {oe, so}, 2'b10);
    idle(CYC + 2);
    @(negedge clk);
    chk(oe == 1 && so == 1, "ready poll", {oe, so}, 2'b11);
    tick(); stb = 1; tick();
    @(negedge clk);
    chk(oe == 0, "cleared by start bit", oe, 0);
    cs = 0; tick();
    cur_req = "R7"; check_word('h12, 'hA5A5);

    cur_req = "R2";
    send_cmd(0, 'h13); send_word('h1111); end_frame(1); idle(CYC + 2);
    check_word('h13, 'hFFFF);
    send_cmd(0, 'h14); end_frame(0); idle(CYC + 2);
    check_word('h14, 'hFFFF);
    send_cmd(0, 'h15); send_word('h2222); end_frame(2); idle(CYC + 2);
    check_word('h15, 'hFFFF);

    cur_req = "R3";
    send_cmd(1, 'h22);
    for (int i = 0; i < 6; i++) send_word('hB000 + i);
    end_frame(0); idle(CYC + 2);
    check_word('h22, 'hB004); check_word('h23, 'hB005);
    check_word('h20, 'hB002); check_word('h21, 'hB003);

    cur_req = "R4";
    bound = 'h41;
    send_cmd(1, 'h40); send_word('hC000); send_word('hC001); end_frame(0); idle(CYC + 2);
    check_word('h40, 'hFFFF); check_word('h41, 'hFFFF);
    send_cmd(0, 'h50); send_word('hC002); end_frame(0); idle(CYC + 2);
    check_word('h50, 'hFFFF);
    bound = 256;

    cur_req = "R6";
    wen = 0;
    send_cmd(0, 'h60); send_word('hD000); end_frame(0); idle(CYC + 2);
    check_word('h60, 'hFFFF);
    wen = 1;
    send_cmd(0, 'h61); w = 0; tick(); w = 1; send_word('hD001); end_frame(0); idle(CYC + 2);
    check_word('h61, 'hFFFF);

    cur_req = "R7";
    send_cmd(0, 'h70); send_word('h1234); end_frame(0);
    send_cmd(0, 'h71); send_word('h5678); end_frame(0);
    idle(CYC + 2);
    check_word('h70, 'h1234); check_word('h71, 'hFFFF);

    cur_req = "R5";
    pclr = 0;
    send_cmd(2, 'h00); send_word('h3C3C); end_frame(0); idle(CYC + 2);
    check_word('h00, 'hFFFF);
    pclr = 1;
    send_cmd(2, 'h00); send_word('h3C3C); end_frame(0); idle(CYC + 2);
    check_word('h00, 'h3C3C); check_word('h12, 'h3C3C); check_word('hFF, 'h3C3C);
    idle(300);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end
endmodule